// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the 16-bit execution path of a small microprogrammed accumulator machine. Each clock is one microcycle. In that microcycle the decoded fields of the current microinstruction pick two registers as ALU operands, choose the left operand source, choose the ALU operation and the shift, and say where the result goes. The result can go to a general register, to the memory buffer, or to both. The memory address register can also be loaded from the right operand in the same cycle. The sequencer that drives the fields takes the negative and zero flags back from the block to make its branch decisions.

There are six general registers. Register 0 is the accumulator. Register 1 is the program counter. Register 2 holds the instruction and register 3 is scratch space. Register 4 holds a mask that leaves only the 13 address bits of an instruction word. Register 5 always reads as the constant one.

Memory is an external synchronous port. A read or a write is one request held over two consecutive microcycles. A read returns its data into the memory buffer at the end of the second cycle. The control store and the memory array are not part of this block.

Top module: `ucode_datapath`

## Requirements
- R1: After reset, registers 0 to 3 read as 0, register 4 reads as 0x1FFF, and both the memory address (`mem_addr`) and the memory buffer (`mem_wdata`) read as 0.
- R2: `a_sel` and `b_sel` choose operands by register number 0 to 5. Register 5 always reads as 0x0001, and codes 6 and 7 read as 0. Writes with `c_sel` equal to 5, 6 or 7 change no register.
- R3: When `mux_mbr` is 0, the left ALU operand is the register chosen by `a_sel`. When it is 1, the left operand is the memory buffer. The right operand is always the register chosen by `b_sel`.
- R4: `alu_fn` selects the ALU operation: 00 adds left and right modulo 2^16, 01 is bitwise AND, 10 passes the left operand, 11 is the ones' complement of the left operand.
- R5: `sh_fn` selects the shift of the ALU result onto `bus_out`: 00 none, 01 left by one with a zero fill, 10 right by one (logical) with a zero fill, 11 passes the value unchanged.
- R6: `flag_n` equals bit 15 of the ALU result and `flag_z` is 1 exactly when the ALU result is zero. Both are taken before the shift.
- R7: With `st` at 1, the register chosen by `c_sel` takes `bus_out` at the clock edge that ends the microcycle.
- R8: With `ld_mbr` at 1, the memory buffer takes `bus_out` at the clock edge. With `ld_mar` at 1, the address register takes the low 13 bits of the right operand. `mem_addr` and `mem_wdata` always show these two registers.
- R9: `mem_rd` follows `rd`. When `rd` is held for two consecutive cycles, the memory buffer takes `mem_rdata` at the end of the second cycle; a third consecutive cycle starts a new access. If `ld_mbr` is 1 in a completing cycle, the value from `ld_mbr` wins.
- R10: `mem_wr` follows `wr`. During a write access, the address and buffer keep their values unless the microinstruction loads them itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_mbr | input | 1 | Left operand from memory buffer (1) or A register (0) |
| alu_fn | input | 2 | ALU operation code |
| sh_fn | input | 2 | Shift operation code |
| ld_mbr | input | 1 | Load memory buffer from result |
| ld_mar | input | 1 | Load address register from right operand |
| rd | input | 1 | Memory read request |
| wr | input | 1 | Memory write request |
| st | input | 1 | Store result to general register |
| c_sel | input | 3 | Destination register number |
| b_sel | input | 3 | Right operand register number |
| a_sel | input | 3 | Left operand register number |
| mem_rdata | input | 16 | Data returned by memory |
| bus_out | output | 16 | Shifter result |
| flag_n | output | 1 | ALU result negative |
| flag_z | output | 1 | ALU result zero |
| mem_addr | output | 13 | Memory address register |
| mem_wdata | output | 16 | Memory buffer register |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |

## Verification
The assertions assume that the sequencer issues each read as a run of exactly two `rd` cycles. They also assume that `rd` and `wr` are never both high. Within one microcycle they assume the field values stay still between clock edges. The random stimulus keeps to these rules: ordinary microinstructions always have both strobes low, and memory accesses are issued as two-cycle runs only. Inside those runs the other fields stay random, so the load priority of the memory buffer during the completing read cycle still gets exercised.

// File: rtl/ucode_datapath.sv
module ucode_datapath #(
  parameter int W  = 16,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mbr,
  input  logic [1:0]    alu_fn,
  input  logic [1:0]    sh_fn,
  input  logic          ld_mbr,
  input  logic          ld_mar,
  input  logic          rd,
  input  logic          wr,
  input  logic          st,
  input  logic [2:0]    c_sel,
  input  logic [2:0]    b_sel,
  input  logic [2:0]    a_sel,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  bus_out,
  output logic          flag_n,
  output logic          flag_z,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr
);

  localparam int NWR = 5;
  localparam logic [W-1:0] MASK_RST = {{(W-AW){1'b0}}, {AW{1'b1}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]  gr [NWR];
  logic [W-1:0]  a_lat, b_lat, left_op, alu_res;
  logic [W-1:0]  mbr;
  logic [AW-1:0] mar;
  logic          rd_ph;

  function automatic logic [W-1:0] pick(input logic [2:0] s,
                                        input logic [W-1:0] r0, input logic [W-1:0] r1,
                                        input logic [W-1:0] r2, input logic [W-1:0] r3,
                                        input logic [W-1:0] r4);
    case (s)
      3'd0:    return r0;
      3'd1:    return r1;
      3'd2:    return r2;
      3'd3:    return r3;
      3'd4:    return r4;
      3'd5:    return ONE;
      default: return '0;
    endcase
  endfunction

  assign a_lat   = pick(a_sel, gr[0], gr[1], gr[2], gr[3], gr[4]);
  assign b_lat   = pick(b_sel, gr[0], gr[1], gr[2], gr[3], gr[4]);
  assign left_op = mux_mbr ? mbr : a_lat;

  always_comb begin
    case (alu_fn)
      2'b00:   alu_res = left_op + b_lat;
      2'b01:   alu_res = left_op & b_lat;
      2'b10:   alu_res = left_op;
      default: alu_res = ~left_op;
    endcase
  end

  always_comb begin
    case (sh_fn)
      2'b01:   bus_out = {alu_res[W-2:0], 1'b0};
      2'b10:   bus_out = {1'b0, alu_res[W-1:1]};
      default: bus_out = alu_res;
    endcase
  end

  assign flag_n    = alu_res[W-1];
  assign flag_z    = (alu_res == '0);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = rd;
  assign mem_wr    = wr;

  for (genvar g = 0; g < NWR; g++) begin : g_reg
    localparam logic [W-1:0] RV = (g == 4) ? MASK_RST : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                          gr[g] <= RV;
      else if (st && c_sel == 3'(g))       gr[g] <= bus_out;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbr   <= '0;
      mar   <= '0;
      rd_ph <= 1'b0;
    end else begin
      rd_ph <= rd & ~rd_ph;
      if (ld_mbr)            mbr <= bus_out;
      else if (rd && rd_ph)  mbr <= mem_rdata;
      if (ld_mar)            mar <= b_lat[AW-1:0];
    end
  end

  assert_reg5_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel == 3'd5 && !mux_mbr && alu_fn == 2'b10 && sh_fn == 2'b00) |-> bus_out == ONE);

  assert_left_mbr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mbr && alu_fn == 2'b10 && sh_fn == 2'b00) |-> bus_out == mem_wdata);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_z && sh_fn == 2'b00) |-> bus_out == '0);

  assert_acc_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st && c_sel == 3'd0) |=>
      ((a_sel != 3'd0 || mux_mbr || alu_fn != 2'b10 || sh_fn != 2'b00) || bus_out == $past(bus_out)));

  assert_mar_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> mem_addr == $past(b_lat[AW-1:0]));

  assert_read_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_ph && !ld_mbr) |=> mem_wdata == $past(mem_rdata));

  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ld_mar) |=> $stable(mem_addr));

endmodule

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mux_mbr, ld_mbr, ld_mar, rd, wr, st;
  logic [1:0]  alu_fn, sh_fn;
  logic [2:0]  c_sel, b_sel, a_sel;
  logic [15:0] mem_rdata;
  logic [15:0] bus_out, mem_wdata;
  logic        flag_n, flag_z, mem_rd, mem_wr;
  logic [12:0] mem_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] m_reg [5];
  logic [15:0] m_mbr;
  logic [12:0] m_mar;
  logic        m_ph;

  always #5 clk = ~clk;

  ucode_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .mux_mbr(mux_mbr), .alu_fn(alu_fn), .sh_fn(sh_fn),
    .ld_mbr(ld_mbr), .ld_mar(ld_mar), .rd(rd), .wr(wr), .st(st),
    .c_sel(c_sel), .b_sel(b_sel), .a_sel(a_sel), .mem_rdata(mem_rdata),
    .bus_out(bus_out), .flag_n(flag_n), .flag_z(flag_z), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr));

  function automatic logic [15:0] rsel(input logic [2:0] s);
    if (s < 3'd5) return m_reg[s];
    if (s == 3'd5) return 16'h0001;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] alu_f(input logic [15:0] l, input logic [15:0] r, input logic [1:0] f);
    case (f)
      2'b00:   return l + r;
      2'b01:   return l & r;
      2'b10:   return l;
      default: return ~l;
    endcase
  endfunction

  function automatic logic [15:0] sh_f(input logic [15:0] v, input logic [1:0] f);
    if (f == 2'b01) return v << 1;
    if (f == 2'b10) return v >> 1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ui(input logic m, input logic [1:0] af, input logic [1:0] sf,
                        input logic lb, input logic la, input logic r, input logic w,
                        input logic s, input logic [2:0] c, input logic [2:0] b, input logic [2:0] a);
    @(negedge clk);
    mux_mbr = m; alu_fn = af; sh_fn = sf; ld_mbr = lb; ld_mar = la;
    rd = r; wr = w; st = s; c_sel = c; b_sel = b; a_sel = a;
  endtask

  task automatic cycle(input string req);
    logic [15:0] al, eb;
    logic [15:0] n_mbr;
    logic [12:0] n_mar;
    #2;
    al = alu_f(mux_mbr ? m_mbr : rsel(a_sel), rsel(b_sel), alu_fn);
    eb = sh_f(al, sh_fn);
    chk(req, bus_out, eb);
    chk("R6 flag_n", {15'd0, flag_n}, {15'd0, al[15]});
    chk("R6 flag_z", {15'd0, flag_z}, {15'd0, al == 16'h0});
    chk("R8 mem_addr", {3'd0, mem_addr}, {3'd0, m_mar});
    chk("R8 mem_wdata", mem_wdata, m_mbr);
    chk("R9 mem_rd", {15'd0, mem_rd}, {15'd0, rd});
    chk("R10 mem_wr", {15'd0, mem_wr}, {15'd0, wr});
    n_mbr = ld_mbr ? eb : ((rd && m_ph) ? mem_rdata : m_mbr);
    n_mar = ld_mar ? rsel(b_sel)[12:0] : m_mar;
    @(posedge clk);
    #1;
    if (st && c_sel < 3'd5) m_reg[c_sel] = eb;
    m_mbr = n_mbr;
    m_mar = n_mar;
    m_ph  = rd & ~m_ph;
  endtask

  task automatic rnd_fields(output logic m, output logic [1:0] af, output logic [1:0] sf,
                            output logic lb, output logic s,
                            output logic [2:0] c, output logic [2:0] b, output logic [2:0] a);
    m = 1'($urandom); af = 2'($urandom); sf = 2'($urandom);
    lb = ($urandom % 4) == 0; s = 1'($urandom);
    c = 3'($urandom); b = 3'($urandom); a = 3'($urandom);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; mem_rdata = 16'h0;
    mux_mbr = 0; alu_fn = 0; sh_fn = 0; ld_mbr = 0; ld_mar = 0;
    rd = 0; wr = 0; st = 0; c_sel = 0; b_sel = 0; a_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) m_reg[i] = (i == 4) ? 16'h1FFF : 16'h0;
    m_mbr = 16'h0; m_mar = 13'h0; m_ph = 1'b0;

    // R1: reset values read through pass path
    for (int i = 0; i < 6; i++) begin
      set_ui(0, 2'b10, 2'b00, 0, 0, 0, 0, 0, 3'd0, 3'd0, 3'(i));
      cycle("R1 reset register value");
    end
    set_ui(0, 2'b10, 2'b00, 0, 0, 0, 0, 0, 3'd0, 3'd0, 3'd4);
    #2;
    chk("R1 AMASK reset", bus_out, 16'h1FFF);
    chk("R1 MAR reset", {3'd0, mem_addr}, 16'h0);
    cycle("R1 reset");

    // R2: write to register 5 ignored, codes 6/7 read zero
    set_ui(0, 2'b11, 2'b00, 0, 0, 0, 0, 1, 3'd5, 3'd0, 3'd0);
    cycle("R7 complement store");
    set_ui(0, 2'b10, 2'b00, 0, 0, 0, 0, 0, 3'd0, 3'd0, 3'd5);
    #2; chk("R2 reg5 stays one", bus_out, 16'h0001);
    cycle("R2 reg5 read");
    set_ui(0, 2'b10, 2'b00, 0, 0, 0, 0, 1, 3'd6, 3'd0, 3'd6);
    #2; chk("R2 reg6 reads zero", bus_out, 16'h0000);
    cycle("R2 reg6");

    // R9: two-cycle read of an instruction word, then R3/R4 mask
    mem_rdata = 16'hE123;
    set_ui(0, 2'b10, 2'b00, 0, 0, 1, 0, 0, 3'd0, 3'd0, 3'd0);
    cycle("R9 read cycle 1");
    set_ui(0, 2'b10, 2'b00, 0, 0, 1, 0, 0, 3'd0, 3'd0, 3'd0);
    cycle("R9 read cycle 2");
    set_ui(1, 2'b10, 2'b00, 0, 0, 0, 0, 1, 3'd2, 3'd0, 3'd0);
    #2; chk("R9 data in buffer", mem_wdata, 16'hE123);
    cycle("R3 mbr to IR");
    set_ui(0, 2'b01, 2'b00, 0, 1, 0, 0, 0, 3'd0, 3'd4, 3'd2);
    #2; chk("R4 and with mask", bus_out, 16'h0123);
    cycle("R4 and");
    set_ui(0, 2'b10, 2'b10, 0, 0, 0, 0, 0, 3'd0, 3'd0, 3'd2);
    #2; chk("R8 MAR from B", {3'd0, mem_addr}, 16'h1FFF & 16'h1FFF);
    chk("R5 right shift", bus_out, 16'h7091);
    cycle("R5 right");
    set_ui(0, 2'b00, 2'b01, 0, 0, 0, 0, 0, 3'd0, 3'd2, 3'd2);
    #2; chk("R6 N before shift", {15'd0, flag_n}, 16'h1);
    chk("R5 left shift of sum", bus_out, 16'h848C);
    cycle("R5 left");

    // R9: ld_mbr wins in completing read cycle
    mem_rdata = 16'hBEEF;
    set_ui(0, 2'b10, 2'b00, 0, 0, 1, 0, 0, 3'd0, 3'd0, 3'd0);
    cycle("R9 read 1");
    set_ui(0, 2'b10, 2'b00, 1, 0, 1, 0, 0, 3'd0, 3'd0, 3'd5);
    cycle("R9 read 2 with load");
    set_ui(0, 2'b10, 2'b00, 0, 0, 0, 0, 0, 3'd0, 3'd0, 3'd0);
    #2; chk("R9 load priority", mem_wdata, 16'h0001);
    cycle("R9 after");

    // Random microinstructions
    for (int k = 0; k < 1500; k++) begin
      logic m, lb, s;
      logic [1:0] af, sf;
      logic [2:0] c, b, a;
      int kind;
      kind = $urandom % 8;
      if (kind == 0 || kind == 1) begin
        for (int p = 0; p < 2; p++) begin
          rnd_fields(m, af, sf, lb, s, c, b, a);
          mem_rdata = 16'($urandom);
          set_ui(m, af, sf, lb, 0, kind == 0, kind == 1, s, c, b, a);
          cycle(kind == 0 ? "R9 random read" : "R10 random write");
        end
      end else begin
        rnd_fields(m, af, sf, lb, s, c, b, a);
        set_ui(m, af, sf, lb, ($urandom % 3) == 0, 0, 0, s, c, b, a);
        cycle("R4 random op");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule